// File: doc/BRIEF.md
# SPI Pin Routing and Stall Controller

This block sits between a serial shift engine and the pads of an SPI port. It maps the engine's serial output and input onto the two data pins in one of four routings: ordinary full duplex, swapped pins, or a single shared wire on either pin. It drives the pad output enables and applies a per-line polarity to the chip-select outputs. It can free the upper chip-select pads for other use. Received bits are captured on the nominal sampling strobe or one clock later.

A small state machine tracks the frame. It has three states: `ST_IDLE` (no line selected), `ST_ACTIVE` (frame running) and `ST_STALL` (frame held). The transitions are:
- `ST_IDLE -> ST_ACTIVE`: a line is selected.
- `ST_IDLE -> ST_STALL`: a line is selected while a FIFO condition is pending and stalling is on.
- `ST_ACTIVE -> ST_STALL`: the transmit FIFO is empty or the receive FIFO is full, with stalling on.
- `ST_STALL -> ST_ACTIVE`: that condition clears.
- `ST_ACTIVE/ST_STALL -> ST_IDLE`: the selection drops.

When stalling is switched off, the frame keeps running. A word started with no transmit data is sent as all ones. A word started with the receive FIFO full, or with no transmit data, sets a sticky flag.

Top module: `spi_pin_stall_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `stall`, `rx_valid`, `underrun_flag` and `overrun_flag` are 0. Each chip-select output sits at its inactive level, which is the inverse of its polarity bit.
- R2: Pin mode 2'b00 takes received data from `sin_i` and drives `sout_oe`. Mode 2'b11 takes received data from `sout_i` and drives `sin_oe`. The unused pin's enable stays 0. The data pin's enable is 1 whenever a frame is active.
- R3: In pin mode 2'b01 (shared `sin`) and mode 2'b10 (shared `sout`), data is both received and driven on that one pin. Its enable is 1 only while a frame is active and `eng_tx_dir` is 1. The other pin's enable stays 0.
- R4: During a frame, both pin data outputs carry the transmit bit. Between frames they keep the last bit driven during the frame. In modes 2'b00 and 2'b11 the driving pin's enable stays 1 between frames when `cfg_out_tristate` is 0, and is 0 when it is 1.
- R5: The frame starts (`ST_ACTIVE`/`ST_STALL`) the cycle after `eng_cs_sel` is nonzero. Chip-select line i is at its active level, equal to `cfg_cs_pol[i]`, exactly when it was selected in the previous cycle. Otherwise it is at the inverse level.
- R6: `cs_oe[i]` is 1 for every line, except that lines at index `CS_SPLIT` and above have `cs_oe` 0 while `cfg_cs_hi_off` is 1.
- R7: With `cfg_no_stall` at 0, `stall` is 1 in a cycle exactly when, in the previous cycle, a line was selected and `fifo_tx_empty` or `fifo_rx_full` was 1. With `cfg_no_stall` at 1, `stall` stays 0.
- R8: With `cfg_no_stall` at 1, an `eng_word_start` in `ST_ACTIVE` with `fifo_tx_empty` set does two things. It forces both pin outputs to 1 until the next word start or the end of the frame. It also sets `underrun_flag`, which stays set until cleared.
- R9: With `cfg_no_stall` at 1, an `eng_word_start` in `ST_ACTIVE` with `fifo_rx_full` set sets `overrun_flag`, which stays set until cleared.
- R10: A `flag_clr` pulse clears both flags on the next edge. A new setting event in the same cycle wins over the clear.
- R11: With `cfg_late_sample` at 0, the received-pin level present in the same cycle as `eng_sample_pulse` appears on `rx_bit`, with `rx_valid` high, one cycle later. With it at 1, the level from the following cycle is captured, and `rx_valid` rises two cycles after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pin_mode | input | 2 | Data pin routing: 00 normal, 01 shared sin, 10 shared sout, 11 swapped |
| cfg_out_tristate | input | 1 | 1 = release the data pin between frames, 0 = hold it |
| cfg_no_stall | input | 1 | 1 = never pause; underrun/overrun permitted |
| cfg_late_sample | input | 1 | 1 = capture input one clock after the sampling strobe |
| cfg_cs_pol | input | NUM_CS | Per-line active level of chip select |
| cfg_cs_hi_off | input | 1 | Release chip-select pads from index CS_SPLIT upward |
| eng_cs_sel | input | NUM_CS | Chip-select lines the engine requests |
| eng_tx_bit | input | 1 | Serial transmit bit from the engine |
| eng_tx_dir | input | 1 | 1 = engine is in a transmit phase (shared-wire modes) |
| eng_word_start | input | 1 | Strobe: engine begins a new word |
| eng_sample_pulse | input | 1 | Strobe: nominal receive sampling edge |
| fifo_tx_empty | input | 1 | Transmit FIFO empty |
| fifo_rx_full | input | 1 | Receive FIFO full |
| flag_clr | input | 1 | Clears underrun and overrun flags |
| sin_i | input | 1 | Level on the sin pad |
| sin_o | output | 1 | Value driven onto the sin pad |
| sin_oe | output | 1 | Output enable of the sin pad |
| sout_i | input | 1 | Level on the sout pad |
| sout_o | output | 1 | Value driven onto the sout pad |
| sout_oe | output | 1 | Output enable of the sout pad |
| cs_o | output | NUM_CS | Chip-select pad levels |
| cs_oe | output | NUM_CS | Chip-select pad enables |
| rx_bit | output | 1 | Captured receive bit |
| rx_valid | output | 1 | Pulse: `rx_bit` updated |
| stall | output | 1 | Frame held for FIFO service |
| underrun_flag | output | 1 | Sticky transmit underrun |
| overrun_flag | output | 1 | Sticky receive overrun |

## Verification
The bench builds the block with `NUM_CS = 4` and `CS_SPLIT = 2`. With these values the upper-pad release covers exactly two lines, while the two lower lines keep their enables. One setting of `cfg_cs_hi_off` therefore shows both sides of the split. The random stimulus steps through all four pin modes, each with stalling on and off. Select patterns are one-hot or empty, so every line sees both polarities while it is selected and while it is not.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_STALL  = 2'd2
    } xfer_state_e;

    typedef enum logic [1:0] {
        PM_FULL       = 2'b00,
        PM_SIN_SHARED = 2'b01,
        PM_SOUT_SHARED = 2'b10,
        PM_SWAP       = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
    import spi_pin_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_no_stall,
    input  logic [NUM_CS-1:0] eng_cs_sel,
    input  logic              eng_word_start,
    input  logic              fifo_tx_empty,
    input  logic              fifo_rx_full,
    input  logic              flag_clr,
    output logic              frame,
    output logic              stall,
    output logic              fill_ones,
    output logic [NUM_CS-1:0] sel_q,
    output logic              underrun_flag,
    output logic              overrun_flag
);

    xfer_state_e state_q, state_d;
    logic        hold_cond;
    logic        word_go;
    logic        set_und, set_ovr;

    assign hold_cond = !cfg_no_stall && (fifo_tx_empty || fifo_rx_full);
    assign word_go   = (state_q == ST_ACTIVE) && eng_word_start;
    assign set_und   = word_go && cfg_no_stall && fifo_tx_empty;
    assign set_ovr   = word_go && cfg_no_stall && fifo_rx_full;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (|eng_cs_sel) state_d = hold_cond ? ST_STALL : ST_ACTIVE;
            ST_ACTIVE: if (!(|eng_cs_sel)) state_d = ST_IDLE;
                       else if (hold_cond) state_d = ST_STALL;
            ST_STALL:  if (!(|eng_cs_sel)) state_d = ST_IDLE;
                       else if (!hold_cond) state_d = ST_ACTIVE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            sel_q         <= '0;
            fill_ones     <= 1'b0;
            underrun_flag <= 1'b0;
            overrun_flag  <= 1'b0;
        end else begin
            state_q       <= state_d;
            sel_q         <= eng_cs_sel;
            if (word_go) fill_ones <= set_und;
            else if (state_q == ST_IDLE) fill_ones <= 1'b0;
            underrun_flag <= (underrun_flag && !flag_clr) || set_und;
            overrun_flag  <= (overrun_flag && !flag_clr) || set_ovr;
        end
    end

    always_comb begin
        frame = (state_q != ST_IDLE);
        stall = (state_q == ST_STALL);
    end

    p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> $past(!cfg_no_stall && (fifo_tx_empty || fifo_rx_full) && (|eng_cs_sel)));

    p_und_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_flag && !flag_clr) |=> underrun_flag);

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_flag && !flag_clr) |=> overrun_flag);

endmodule

// File: rtl/spi_pin_router.sv
module spi_pin_router
    import spi_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_pin_mode,
    input  logic       cfg_out_tristate,
    input  logic       frame,
    input  logic       tx_dir,
    input  logic       tx_val,
    input  logic       sin_i,
    input  logic       sout_i,
    output logic       sin_o,
    output logic       sin_oe,
    output logic       sout_o,
    output logic       sout_oe,
    output logic       rx_pin
);

    pin_mode_e mode;
    logic      hold_q;
    logic      out_val;
    logic      idle_drive;

    assign mode       = pin_mode_e'(cfg_pin_mode);
    assign out_val    = frame ? tx_val : hold_q;
    assign idle_drive = frame || !cfg_out_tristate;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold_q <= 1'b0;
        else if (frame) hold_q <= tx_val;
    end

    always_comb begin
        sin_o   = out_val;
        sout_o  = out_val;
        sin_oe  = 1'b0;
        sout_oe = 1'b0;
        rx_pin  = sin_i;
        unique case (mode)
            PM_FULL:        sout_oe = idle_drive;
            PM_SIN_SHARED:  sin_oe  = frame && tx_dir;
            PM_SOUT_SHARED: begin
                sout_oe = frame && tx_dir;
                rx_pin  = sout_i;
            end
            PM_SWAP: begin
                sin_oe = idle_drive;
                rx_pin = sout_i;
            end
            default: ;
        endcase
    end

    p_shared_wire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_pin_mode == 2'b01 && sin_oe) || (cfg_pin_mode == 2'b10 && sout_oe)) |-> tx_dir);

    p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sin_oe && sout_oe));

endmodule

// File: rtl/spi_cs_driver.sv
module spi_cs_driver #(
    parameter int NUM_CS   = 4,
    parameter int CS_SPLIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CS-1:0] cfg_cs_pol,
    input  logic              cfg_cs_hi_off,
    input  logic              frame,
    input  logic [NUM_CS-1:0] sel_q,
    output logic [NUM_CS-1:0] cs_o,
    output logic [NUM_CS-1:0] cs_oe
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        if (i >= CS_SPLIT) begin : g_upper
            assign cs_oe[i] = !cfg_cs_hi_off;
        end else begin : g_lower
            assign cs_oe[i] = 1'b1;
        end
        assign cs_o[i] = (frame && sel_q[i]) ? cfg_cs_pol[i] : !cfg_cs_pol[i];
    end

    p_hi_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cs_hi_off |-> (cs_oe[NUM_CS-1:CS_SPLIT] == '0));

endmodule

// File: rtl/spi_rx_sampler.sv
module spi_rx_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_late_sample,
    input  logic sample_pulse,
    input  logic rx_pin,
    output logic rx_bit,
    output logic rx_valid
);

    logic pend_q;
    logic capture;

    assign capture = cfg_late_sample ? pend_q : sample_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            rx_bit   <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            pend_q   <= sample_pulse;
            rx_valid <= capture;
            if (capture) rx_bit <= rx_pin;
        end
    end

    p_valid_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(sample_pulse) || $past(sample_pulse, 2)));

endmodule

// File: rtl/spi_pin_stall_ctrl.sv
module spi_pin_stall_ctrl #(
    parameter int NUM_CS   = 4,
    parameter int CS_SPLIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_pin_mode,
    input  logic              cfg_out_tristate,
    input  logic              cfg_no_stall,
    input  logic              cfg_late_sample,
    input  logic [NUM_CS-1:0] cfg_cs_pol,
    input  logic              cfg_cs_hi_off,
    input  logic [NUM_CS-1:0] eng_cs_sel,
    input  logic              eng_tx_bit,
    input  logic              eng_tx_dir,
    input  logic              eng_word_start,
    input  logic              eng_sample_pulse,
    input  logic              fifo_tx_empty,
    input  logic              fifo_rx_full,
    input  logic              flag_clr,
    input  logic              sin_i,
    output logic              sin_o,
    output logic              sin_oe,
    input  logic              sout_i,
    output logic              sout_o,
    output logic              sout_oe,
    output logic [NUM_CS-1:0] cs_o,
    output logic [NUM_CS-1:0] cs_oe,
    output logic              rx_bit,
    output logic              rx_valid,
    output logic              stall,
    output logic              underrun_flag,
    output logic              overrun_flag
);

    logic              frame;
    logic              fill_ones;
    logic              tx_val;
    logic              rx_pin;
    logic [NUM_CS-1:0] sel_q;

    assign tx_val = fill_ones || eng_tx_bit;

    spi_xfer_fsm #(.NUM_CS(NUM_CS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_no_stall  (cfg_no_stall),
        .eng_cs_sel    (eng_cs_sel),
        .eng_word_start(eng_word_start),
        .fifo_tx_empty (fifo_tx_empty),
        .fifo_rx_full  (fifo_rx_full),
        .flag_clr      (flag_clr),
        .frame         (frame),
        .stall         (stall),
        .fill_ones     (fill_ones),
        .sel_q         (sel_q),
        .underrun_flag (underrun_flag),
        .overrun_flag  (overrun_flag)
    );

    spi_pin_router u_router (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_pin_mode    (cfg_pin_mode),
        .cfg_out_tristate(cfg_out_tristate),
        .frame           (frame),
        .tx_dir          (eng_tx_dir),
        .tx_val          (tx_val),
        .sin_i           (sin_i),
        .sout_i          (sout_i),
        .sin_o           (sin_o),
        .sin_oe          (sin_oe),
        .sout_o          (sout_o),
        .sout_oe         (sout_oe),
        .rx_pin          (rx_pin)
    );

    spi_cs_driver #(.NUM_CS(NUM_CS), .CS_SPLIT(CS_SPLIT)) u_cs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_cs_pol   (cfg_cs_pol),
        .cfg_cs_hi_off(cfg_cs_hi_off),
        .frame        (frame),
        .sel_q        (sel_q),
        .cs_o         (cs_o),
        .cs_oe        (cs_oe)
    );

    spi_rx_sampler u_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_late_sample(cfg_late_sample),
        .sample_pulse   (eng_sample_pulse),
        .rx_pin         (rx_pin),
        .rx_bit         (rx_bit),
        .rx_valid       (rx_valid)
    );

endmodule

// File: tb/spi_pin_stall_ctrl_bench.sv
module spi_pin_stall_ctrl_bench;

    localparam int NUM_CS   = 4;
    localparam int CS_SPLIT = 2;
    localparam int CYCLES   = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_pin_mode = '0;
    logic cfg_out_tristate = 1'b1, cfg_no_stall = 1'b0, cfg_late_sample = 1'b0;
    logic [NUM_CS-1:0] cfg_cs_pol = '0;
    logic cfg_cs_hi_off = 1'b0;
    logic [NUM_CS-1:0] eng_cs_sel = '0;
    logic eng_tx_bit = 0, eng_tx_dir = 0, eng_word_start = 0, eng_sample_pulse = 0;
    logic fifo_tx_empty = 0, fifo_rx_full = 0, flag_clr = 0, sin_i = 0, sout_i = 0;
    logic sin_o, sin_oe, sout_o, sout_oe, rx_bit, rx_valid, stall, underrun_flag, overrun_flag;
    logic [NUM_CS-1:0] cs_o, cs_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_pin_stall_ctrl #(.NUM_CS(NUM_CS), .CS_SPLIT(CS_SPLIT)) u_spi_pin_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_pin_mode(cfg_pin_mode),
        .cfg_out_tristate(cfg_out_tristate), .cfg_no_stall(cfg_no_stall),
        .cfg_late_sample(cfg_late_sample), .cfg_cs_pol(cfg_cs_pol),
        .cfg_cs_hi_off(cfg_cs_hi_off), .eng_cs_sel(eng_cs_sel),
        .eng_tx_bit(eng_tx_bit), .eng_tx_dir(eng_tx_dir),
        .eng_word_start(eng_word_start), .eng_sample_pulse(eng_sample_pulse),
        .fifo_tx_empty(fifo_tx_empty), .fifo_rx_full(fifo_rx_full),
        .flag_clr(flag_clr), .sin_i(sin_i), .sin_o(sin_o), .sin_oe(sin_oe),
        .sout_i(sout_i), .sout_o(sout_o), .sout_oe(sout_oe),
        .cs_o(cs_o), .cs_oe(cs_oe), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .stall(stall), .underrun_flag(underrun_flag), .overrun_flag(overrun_flag)
    );

    // Expected-state model built from the requirements
    int m_state = 0;            // 0 idle, 1 active, 2 stalled
    logic [NUM_CS-1:0] m_sel = '0;
    logic m_fill = 0, m_und = 0, m_ovr = 0, m_hold = 0;
    logic m_pend = 0, m_rxb = 0, m_rxv = 0;

    function automatic logic rx_src(input logic [1:0] mode, input logic a, input logic b);
        return mode[1] ? b : a;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_sel = '0; m_fill = 0; m_und = 0; m_ovr = 0;
            m_hold = 0; m_pend = 0; m_rxb = 0; m_rxv = 0;
        end else begin
            logic frame_p, txv_p, pin_p, go, cap, su, so;
            int ns;
            frame_p = (m_state != 0);
            txv_p   = m_fill | eng_tx_bit;
            pin_p   = rx_src(cfg_pin_mode, sin_i, sout_i);
            if (frame_p) m_hold = txv_p;
            if (eng_cs_sel == '0) ns = 0;
            else if (!cfg_no_stall && (fifo_tx_empty || fifo_rx_full)) ns = 2;
            else ns = 1;
            go = (m_state == 1) && eng_word_start;
            su = go && cfg_no_stall && fifo_tx_empty;
            so = go && cfg_no_stall && fifo_rx_full;
            if (go) m_fill = su;
            else if (m_state == 0) m_fill = 0;
            m_und = (m_und & ~flag_clr) | su;
            m_ovr = (m_ovr & ~flag_clr) | so;
            cap = cfg_late_sample ? m_pend : eng_sample_pulse;
            if (cap) m_rxb = pin_p;
            m_rxv  = cap;
            m_pend = eng_sample_pulse;
            m_state = ns;
            m_sel = eng_cs_sel;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic frame, txv, eo, drv, e_sin, e_sout;
        frame = (m_state != 0);
        txv = m_fill | eng_tx_bit;
        eo  = frame ? txv : m_hold;
        drv = frame | ~cfg_out_tristate;
        e_sin = 0; e_sout = 0;
        case (cfg_pin_mode)
            2'b00: e_sout = drv;
            2'b01: e_sin  = frame & eng_tx_dir;
            2'b10: e_sout = frame & eng_tx_dir;
            default: e_sin = drv;
        endcase
        if (cfg_pin_mode == 2'b01 || cfg_pin_mode == 2'b10) begin
            chk("R3 sin_oe", sin_oe, e_sin);
            chk("R3 sout_oe", sout_oe, e_sout);
        end else begin
            chk("R2/R4 sin_oe", sin_oe, e_sin);
            chk("R2/R4 sout_oe", sout_oe, e_sout);
        end
        chk("R4,R8 sin_o", sin_o, eo);
        chk("R4,R8 sout_o", sout_o, eo);
        for (int i = 0; i < NUM_CS; i++) begin
            chk("R5 cs_o", cs_o[i], m_sel[i] ? cfg_cs_pol[i] : ~cfg_cs_pol[i]);
            chk("R6 cs_oe", cs_oe[i], !(cfg_cs_hi_off && i >= CS_SPLIT));
        end
        chk("R7 stall", stall, m_state == 2);
        chk("R8,R10 underrun_flag", underrun_flag, m_und);
        chk("R9,R10 overrun_flag", overrun_flag, m_ovr);
        chk("R11 rx_valid", rx_valid, m_rxv);
        chk("R11 rx_bit", rx_bit, m_rxb);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        cfg_cs_pol = 4'b0101;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 stall", stall, 1'b0);
        chk("R1 rx_valid", rx_valid, 1'b0);
        chk("R1 underrun_flag", underrun_flag, 1'b0);
        chk("R1 overrun_flag", overrun_flag, 1'b0);
        for (int i = 0; i < NUM_CS; i++) chk("R1 cs_o", cs_o[i], ~cfg_cs_pol[i]);
        check_all();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stall after release", stall, 1'b0);
        check_all();

        // Directed R8: underrun with stalling off, then clear (R10)
        cfg_no_stall = 1; cfg_pin_mode = 2'b00; eng_cs_sel = 4'b0001; eng_tx_bit = 0;
        @(negedge clk); check_all();
        eng_word_start = 1; fifo_tx_empty = 1;
        @(negedge clk); check_all();
        eng_word_start = 0; fifo_tx_empty = 0;
        chk("R8 fill ones", sout_o, 1'b1);
        chk("R8 flag set", underrun_flag, 1'b1);
        flag_clr = 1;
        @(negedge clk); check_all();
        flag_clr = 0;
        chk("R10 flag cleared", underrun_flag, 1'b0);
        eng_cs_sel = '0;
        @(negedge clk); check_all();

        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            if (cyc % 250 == 0) begin
                int seg = cyc / 250;
                cfg_pin_mode     = 2'(seg % 4);
                cfg_no_stall     = ((seg / 4) % 2) == 1;
                cfg_out_tristate = $urandom % 2;
                cfg_late_sample  = $urandom % 2;
                cfg_cs_hi_off    = $urandom % 2;
                cfg_cs_pol       = NUM_CS'($urandom);
            end
            if ($urandom % 12 == 0) begin
                int r = $urandom % (NUM_CS + 2);
                eng_cs_sel = (r < 2) ? '0 : NUM_CS'(1 << (r - 2));
            end
            eng_tx_bit       = $urandom % 2;
            eng_tx_dir       = $urandom % 2;
            eng_word_start   = ($urandom % 6) == 0;
            eng_sample_pulse = ($urandom % 3) == 0;
            fifo_tx_empty    = ($urandom % 8) == 0;
            fifo_rx_full     = ($urandom % 10) == 0;
            flag_clr         = ($urandom % 25) == 0;
            sin_i            = $urandom % 2;
            sout_i           = $urandom % 2;
            @(negedge clk);
            check_all();
        end
        finish_up();
    end

endmodule